// File: doc/BRIEF.md
# Byte-wide command-driven flash array

This block is a memory-mapped, byte-wide non-volatile store that a host drives the way it would drive a classic command-set flash part. Every host write is taken as a command byte unless a two-cycle sequence is in progress. Commands choose what reads return (stored bytes, the status register or a 16-bit device identifier), program one byte, or erase one block back to 0xFF. The storage is an on-chip byte array with a parameterised size and a power-of-two block size.

Operations finish at once: a program or an erase takes effect on the clock edge that accepts its second cycle, and there is no busy or wait handshake. A read issued in one cycle returns its data in the next, marked by a one-cycle valid strobe. Command codes follow the classic set: 0xFF array read, 0x70 status read, 0x90 identifier read, 0xB0 suspend/resume, 0x50 status clear, 0x40 or 0x10 byte program, 0x20 erase setup, and 0xD0 erase confirm.

Top module: `byteflash`

## Requirements
- R1: After reset the device is in array-read mode, the status register is 0x00, no two-cycle sequence is open, every byte of the array reads 0xFF, and `rd_valid` is low.
- R2: A read accepted on `rd_en` presents its data on `rd_data` with `rd_valid` high in the following cycle only; in a cycle that follows no read, `rd_valid` is low.
- R3: A first-cycle write of 0xFF, 0x70, 0x90 or 0xB0 selects array, status, identifier or suspend mode in one cycle, whatever the address; in suspend mode every read returns 0xFF.
- R4: A first-cycle write of 0x50 sets the status register to 0x00 and returns the device to array-read mode in the same cycle.
- R5: A first-cycle write of 0x40 or 0x10 makes the next write a data cycle that stores its byte at its address when the address is below `MEM_BYTES`, and stores nothing otherwise; until the next mode command, reads return 0xFF.
- R6: After a first-cycle 0x20, a data cycle of 0xD0 fills with 0xFF the whole block holding its address (address aligned down to `BLK_BYTES`) and leaves every other byte unchanged; reads then return 0xFF until the next mode command.
- R7: After a first-cycle 0x20, a data cycle of any byte other than 0xD0 erases nothing, switches to status-read mode and sets status bit 5 (erase error) and bit 4 (byte-write error); a status read then returns 0x30.
- R8: In status-read mode a read returns the status register; bits 7, 6, 3, 2, 1 and 0 read as 0, since operations are instant and no voltage is sensed.
- R9: In identifier mode a read at an even address returns bits 7:0 of `DEV_ID` and at an odd address bits 15:8.
- R10: In array-read mode a read at an address of `MEM_BYTES` or above returns 0xFF.
- R11: A first-cycle byte that is not one of the listed commands changes neither mode nor status; after any second cycle the next write is decoded as a command again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe for this cycle |
| rd_en | input | 1 | Host read strobe for this cycle |
| addr | input | ADDR_W | Byte address of the access |
| wr_data | input | 8 | Command or data byte of a write |
| rd_data | output | 8 | Read result, held until the next read |
| rd_valid | output | 1 | High for one cycle when `rd_data` carries a new result |

## Verification
A write changes mode, status or array contents at the rising edge that accepts it, so the first read that can see the effect is the one issued in the next cycle, and its data is due one further edge later with `rd_valid`. The bench drives each access half a period before an edge and compares `rd_valid` and `rd_data` against its behavioural model at the following falling edge, one full cycle after issue, on every cycle of the run. Corner reads (out-of-range addresses, block edges next to an erased block, odd and even identifier bytes, status after a bad confirm) are also checked against constants worked out by hand from the requirements.

// File: rtl/byteflash_pkg.sv
// Package byteflash_pkg
// Shared command codes, the mode type and the status bit positions of the
// byte-wide flash block. Assumes an 8-bit command bus.
package byteflash_pkg;

    localparam logic [7:0] OP_MODE_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_MODE_STATUS = 8'h70;
    localparam logic [7:0] OP_MODE_IDENT  = 8'h90;
    localparam logic [7:0] OP_SUSPEND     = 8'hB0;
    localparam logic [7:0] OP_CLEAR       = 8'h50;
    localparam logic [7:0] OP_PROG_MAIN   = 8'h40;
    localparam logic [7:0] OP_PROG_ALT    = 8'h10;
    localparam logic [7:0] OP_ERASE_ARM   = 8'h20;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;

    // Status bits set by a failed erase confirm: erase error (5), write error (4)
    localparam logic [7:0] ST_CONFIRM_ERR = 8'h30;

    typedef enum logic [2:0] {
        MD_ARRAY   = 3'd0,
        MD_STATUS  = 3'd1,
        MD_IDENT   = 3'd2,
        MD_SUSPEND = 3'd3,
        MD_PROG    = 3'd4,
        MD_ERASE   = 3'd5
    } mode_t;

    // True when a byte is one of the recognised first-cycle commands
    function automatic logic is_known_op(input logic [7:0] b);
        return (b == OP_MODE_ARRAY) || (b == OP_MODE_STATUS) ||
               (b == OP_MODE_IDENT) || (b == OP_SUSPEND) ||
               (b == OP_CLEAR) || (b == OP_PROG_MAIN) ||
               (b == OP_PROG_ALT) || (b == OP_ERASE_ARM);
    endfunction

endpackage

// File: rtl/byteflash_ctrl.sv
// Module byteflash_ctrl
// Decodes host writes into the current mode, the second-cycle flag and the
// status register, and raises one-cycle program and erase strobes for the
// array. Assumes in_range is already qualified against the array size.
module byteflash_ctrl
    import byteflash_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       in_range,
    output mode_t      mode,
    output logic       second,
    output logic [7:0] status,
    output logic       prog_stb,
    output logic       erase_stb
);

    // Strobes for the array: only on an in-range second cycle
    always_comb begin
        prog_stb  = wr_en && second && (mode == MD_PROG) && in_range;
        erase_stb = wr_en && second && (mode == MD_ERASE) &&
                    (wr_data == OP_ERASE_GO) && in_range;
    end

    // Command state machine: first-cycle decode, second-cycle completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= MD_ARRAY;
            second <= 1'b0;
            status <= 8'h00;
        end else if (wr_en) begin
            if (!second) begin
                case (wr_data)
                    OP_MODE_ARRAY:  mode <= MD_ARRAY;
                    OP_MODE_STATUS: mode <= MD_STATUS;
                    OP_MODE_IDENT:  mode <= MD_IDENT;
                    OP_SUSPEND:     mode <= MD_SUSPEND;
                    OP_CLEAR: begin
                        status <= 8'h00;
                        mode   <= MD_ARRAY;
                    end
                    OP_PROG_MAIN, OP_PROG_ALT: begin
                        mode   <= MD_PROG;
                        second <= 1'b1;
                    end
                    OP_ERASE_ARM: begin
                        mode   <= MD_ERASE;
                        second <= 1'b1;
                    end
                    default: ;
                endcase
            end else begin
                second <= 1'b0;
                if ((mode == MD_ERASE) && (wr_data != OP_ERASE_GO)) begin
                    mode   <= MD_STATUS;
                    status <= status | ST_CONFIRM_ERR;
                end
            end
        end
    end

endmodule

// File: rtl/byteflash_array.sv
// Module byteflash_array
// Byte storage with a single-byte program port and a whole-block erase.
// Assumes MEM_BYTES and BLK_BYTES are powers of two, BLK_BYTES >= 2 and
// BLK_BYTES <= MEM_BYTES. Reset fills every cell with 0xFF.
module byteflash_array #(
    parameter int MEM_BYTES = 256,
    parameter int BLK_BYTES = 32,
    localparam int MEM_AW   = $clog2(MEM_BYTES),
    localparam int BLK_AW   = $clog2(BLK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_stb,
    input  logic              erase_stb,
    input  logic [MEM_AW-1:0] cell_addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        cell_q
);

    logic [7:0] cells [MEM_BYTES];

    for (genvar i = 0; i < MEM_BYTES; i++) begin : g_cell
        localparam logic [MEM_AW-1:0] IDX = MEM_AW'(i);
        // One cell: erase by block match, program by exact address match
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cells[i] <= 8'hFF;
            end else if (erase_stb &&
                         (cell_addr[MEM_AW-1:BLK_AW] == IDX[MEM_AW-1:BLK_AW])) begin
                cells[i] <= 8'hFF;
            end else if (prog_stb && (cell_addr == IDX)) begin
                cells[i] <= wr_data;
            end
        end
    end

    // Combinational read of the addressed cell
    assign cell_q = cells[cell_addr];

endmodule

// File: rtl/byteflash_rdport.sv
// Module byteflash_rdport
// Registers the read result chosen by the current mode, with a one-cycle
// valid strobe. Assumes the mode and status seen are those before any write
// in the same cycle.
module byteflash_rdport
    import byteflash_pkg::*;
#(
    parameter logic [15:0] DEV_ID = 16'h89A2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en,
    input  mode_t      mode,
    input  logic       in_range,
    input  logic       addr_odd,
    input  logic [7:0] cell_q,
    input  logic [7:0] status,
    output logic [7:0] rd_data,
    output logic       rd_valid
);

    logic [7:0] pick;

    // Mode-dependent selection of the read byte
    always_comb begin
        case (mode)
            MD_ARRAY:  pick = in_range ? cell_q : 8'hFF;
            MD_STATUS: pick = status;
            MD_IDENT:  pick = addr_odd ? DEV_ID[15:8] : DEV_ID[7:0];
            default:   pick = 8'hFF;
        endcase
    end

    // Output register: capture on a read, strobe valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= pick;
            end
        end
    end

endmodule

// File: rtl/byteflash.sv
// Module byteflash
// Top of the byte-wide command flash: command decoder, byte array and
// registered read port. Assumes the host never needs a wait state; every
// access is accepted in the cycle it is presented.
module byteflash
    import byteflash_pkg::*;
#(
    parameter int          ADDR_W    = 10,
    parameter int          MEM_BYTES = 256,
    parameter int          BLK_BYTES = 32,
    parameter logic [15:0] DEV_ID    = 16'h89A2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);

    localparam int              MEM_AW = $clog2(MEM_BYTES);
    localparam logic [ADDR_W:0] LIMIT  = (ADDR_W + 1)'(MEM_BYTES);

    mode_t      mode;
    logic       second;
    logic [7:0] status;
    logic       prog_stb;
    logic       erase_stb;
    logic [7:0] cell_q;
    logic       in_range;

    // Address qualification against the array size
    assign in_range = ({1'b0, addr} < LIMIT);

    byteflash_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .in_range  (in_range),
        .mode      (mode),
        .second    (second),
        .status    (status),
        .prog_stb  (prog_stb),
        .erase_stb (erase_stb)
    );

    byteflash_array #(
        .MEM_BYTES (MEM_BYTES),
        .BLK_BYTES (BLK_BYTES)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_stb  (prog_stb),
        .erase_stb (erase_stb),
        .cell_addr (addr[MEM_AW-1:0]),
        .wr_data   (wr_data),
        .cell_q    (cell_q)
    );

    byteflash_rdport #(
        .DEV_ID (DEV_ID)
    ) u_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .mode     (mode),
        .in_range (in_range),
        .addr_odd (addr[0]),
        .cell_q   (cell_q),
        .status   (status),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/byteflash_chk.sv
// Module byteflash_chk
// Protocol assertions for byteflash, bound to every instance of the top.
module byteflash_chk
    import byteflash_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wr_data,
    input mode_t      mode,
    input logic       second,
    input logic [7:0] status,
    input logic [7:0] rd_data,
    input logic       rd_valid
);

    // R2
    rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R2
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R4
    clear_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !second && (wr_data == OP_CLEAR)) |=>
            ((status == 8'h00) && (mode == MD_ARRAY)));

    // R7
    bad_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && second && (mode == MD_ERASE) && (wr_data != OP_ERASE_GO)) |=>
            ((status[5:4] == 2'b11) && (mode == MD_STATUS)));

    // R8
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (mode == MD_STATUS)) |=> (rd_data == $past(status)));

    // R11
    second_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && second) |=> !second);

    // R11
    unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !second && !is_known_op(wr_data)) |=>
            ($stable(mode) && $stable(status) && !second));

endmodule

bind byteflash byteflash_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wr_data  (wr_data),
    .mode     (mode),
    .second   (second),
    .status   (status),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
);

// File: tb/byteflash_tb.sv
// Bench for byteflash: behavioural model compared on every clock.
module byteflash_tb;

    localparam int          ADDR_W    = 10;
    localparam int          MEM_BYTES = 256;
    localparam int          BLK_BYTES = 32;
    localparam logic [15:0] DEV_ID    = 16'h89A2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wr_data = 8'h00;
    logic [7:0]        rd_data;
    logic              rd_valid;

    always #4 clk = ~clk;

    byteflash #(
        .ADDR_W    (ADDR_W),
        .MEM_BYTES (MEM_BYTES),
        .BLK_BYTES (BLK_BYTES),
        .DEV_ID    (DEV_ID)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Behavioural model state (0 array,1 status,2 ident,3 suspend,4 prog,5 erase)
    byte unsigned m_mem [MEM_BYTES];
    int           m_mode;
    bit           m_cyc;
    byte unsigned m_st;

    bit           pend_v = 1'b0;
    byte unsigned pend_d = 8'h00;
    string        pend_tag = "R1";

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic byte unsigned model_read(input int a);
        case (m_mode)
            0: return (a < MEM_BYTES) ? m_mem[a] : 8'hFF;
            1: return m_st;
            2: return (a % 2 == 1) ? DEV_ID[15:8] : DEV_ID[7:0];
            default: return 8'hFF;
        endcase
    endfunction

    task automatic model_write(input int a, input byte unsigned d);
        if (!m_cyc) begin
            case (d)
                8'hFF: m_mode = 0;
                8'h70: m_mode = 1;
                8'h90: m_mode = 2;
                8'hB0: m_mode = 3;
                8'h50: begin m_st = 0; m_mode = 0; end
                8'h40, 8'h10: begin m_mode = 4; m_cyc = 1; end
                8'h20: begin m_mode = 5; m_cyc = 1; end
                default: ;
            endcase
        end else begin
            m_cyc = 0;
            if (m_mode == 4) begin
                if (a < MEM_BYTES) m_mem[a] = d;
            end else if (m_mode == 5) begin
                if (d == 8'hD0) begin
                    if (a < MEM_BYTES) begin
                        int base = a - (a % BLK_BYTES);
                        for (int k = 0; k < BLK_BYTES; k++) m_mem[base + k] = 8'hFF;
                    end
                end else begin
                    m_mode = 1;
                    m_st   = m_st | 8'h30;
                end
            end
        end
    endtask

    // One clock: check last cycle's result, drive this cycle, update model
    task automatic step(input bit w, input bit r, input int a, input byte unsigned d,
                        input string tag);
        check(rd_valid === pend_v, {pend_tag, " rd_valid"}, int'(rd_valid), int'(pend_v));
        if (pend_v)
            check(rd_data === pend_d, {pend_tag, " rd_data"}, int'(rd_data), int'(pend_d));
        wr_en   = w;
        rd_en   = r;
        addr    = ADDR_W'(a);
        wr_data = d;
        pend_v  = r;
        pend_d  = model_read(a);
        pend_tag = tag;
        if (w) model_write(a, d);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input byte unsigned d, input string tag);
        step(1'b1, 1'b0, a, d, tag);
    endtask

    // Read and also compare against a hand-derived constant
    task automatic rd_expect(input int a, input byte unsigned exp, input string tag);
        step(1'b0, 1'b1, a, 8'h00, tag);
        step(1'b0, 1'b0, 0, 8'h00, tag);
        check(rd_data === exp, {tag, " constant"}, int'(rd_data), int'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < MEM_BYTES; k++) m_mem[k] = 8'hFF;
        m_mode = 0; m_cyc = 0; m_st = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(rd_valid === 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
        rd_expect(0, 8'hFF, "R1");
        rd_expect(MEM_BYTES - 1, 8'hFF, "R1");
        // R2 back-to-back reads keep valid high each cycle
        step(1'b0, 1'b1, 1, 8'h00, "R2");
        step(1'b0, 1'b1, 2, 8'h00, "R2");
        step(1'b0, 1'b0, 0, 8'h00, "R2");
        // R5 program with both codes, first-cycle address ignored
        wr(700, 8'h40, "R5"); wr(5, 8'hA5, "R5");
        rd_expect(5, 8'hFF, "R5");
        wr(3, 8'h10, "R5"); wr(6, 8'h3C, "R5");
        wr(999, 8'hFF, "R3");
        rd_expect(5, 8'hA5, "R5");
        rd_expect(6, 8'h3C, "R5");
        // R10 out-of-range program dropped, out-of-range read gives 0xFF
        wr(0, 8'h40, "R5"); wr(300, 8'h77, "R5");
        wr(0, 8'hFF, "R3");
        rd_expect(300, 8'hFF, "R10");
        rd_expect(300 % MEM_BYTES, 8'hFF, "R5");
        // R6 erase middle block, neighbours kept
        wr(0, 8'h40, "R6"); wr(31, 8'h11, "R6");
        wr(0, 8'h40, "R6"); wr(32, 8'h22, "R6");
        wr(0, 8'h40, "R6"); wr(63, 8'h33, "R6");
        wr(0, 8'h40, "R6"); wr(64, 8'h44, "R6");
        wr(0, 8'h20, "R6"); wr(40, 8'hD0, "R6");
        rd_expect(32, 8'hFF, "R6");
        wr(0, 8'hFF, "R3");
        rd_expect(31, 8'h11, "R6");
        rd_expect(32, 8'hFF, "R6");
        rd_expect(63, 8'hFF, "R6");
        rd_expect(64, 8'h44, "R6");
        rd_expect(5, 8'hA5, "R6");
        // R9 identifier bytes
        wr(513, 8'h90, "R9");
        rd_expect(0, DEV_ID[7:0], "R9");
        rd_expect(1, DEV_ID[15:8], "R9");
        rd_expect(7, DEV_ID[15:8], "R9");
        // R3 suspend mode reads 0xFF
        wr(0, 8'hB0, "R3");
        rd_expect(5, 8'hFF, "R3");
        // R8 status mode, clean status
        wr(0, 8'h70, "R8");
        rd_expect(5, 8'h00, "R8");
        // R11 unknown first-cycle byte ignored
        wr(0, 8'h33, "R11");
        rd_expect(5, 8'h00, "R11");
        // R11 second-cycle byte is data, next write is a command again
        wr(0, 8'h40, "R11"); wr(9, 8'h70, "R11");
        wr(0, 8'hFF, "R11");
        rd_expect(9, 8'h70, "R11");
        // R7 bad erase confirm
        wr(0, 8'h20, "R7"); wr(5, 8'h55, "R7");
        rd_expect(0, 8'h30, "R7");
        wr(0, 8'hFF, "R7");
        rd_expect(5, 8'hA5, "R7");
        wr(0, 8'h20, "R7"); wr(5, 8'hFF, "R7");
        rd_expect(1, 8'h30, "R7");
        // R4 clear status back to array mode
        wr(0, 8'h50, "R4");
        rd_expect(5, 8'hA5, "R4");
        wr(0, 8'h70, "R4");
        rd_expect(0, 8'h00, "R4");
        step(1'b0, 1'b0, 0, 8'h00, "R2");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule